// File: doc/BRIEF.md
# Hammer Fire Verification Checker

This block confirms that the print hammers of a line printer with 132 columns fired exactly where the controller told them to. It keeps two separate bit records, with one bit per column. The first record collects the columns the controller decided to strike. The second collects the columns where a strike pulse was actually sensed. The two records are filled through independent streams, so a fault on one path cannot hide in the other.

When a scan boundary strobe arrives, a walker visits the columns in ascending order, one column per clock. At each column it compares the two bits, clears both, and records any disagreement in a per-column fault map. A disagreement also raises an error request. That request is ORed with an external error input. The combined signal reaches the sticky print-check latch only when the sample strobe is high. The first failing column and the kind of its failure are held beside the latch until software-independent clear logic (the `clear` pin) or reset drops them.

Both event inputs use valid/ready. Ready is low for the whole comparison walk. A producer that is held off must keep its valid and column steady until ready returns. Events offered while ready is low are not taken. Control strobes and status outputs are plain pins.

Top module: `hammer_fire_checker`

## Requirements
- R1: After reset, `busy`, `scan_done`, `chk_err`, `err_col_vld`, `err_kind` and `fault_map` are all zero, `err_col` is zero, and both ready outputs are high.
- R2: A fire command is taken only in a cycle where `fire_cmd_valid` and `fire_cmd_ready` are both high. A taken command sets the commanded bit of `fire_cmd_col`. A command whose column is 132 or above is dropped with no effect.
- R3: A sensed pulse follows the same valid/ready and range rules on its own port. It sets the sensed bit of `fire_sense_col`, independently of the commanded record.
- R4: `scan_end` high while idle starts a walk on the next edge. The walk compares column 0 first and then one column per clock in ascending order. `busy` is high and both ready outputs are low while the walk runs. `scan_end` during a walk is ignored.
- R5: `scan_done` is a one-cycle pulse in the cycle after column 131 is compared. That is 132 clock edges after the edge that captured `scan_end`, and `busy` is low in that same cycle.
- R6: A column whose commanded and sensed bits differ sets its own bit in `fault_map` (bit i for column i) and raises the error request. A column with both bits set, or neither, records nothing.
- R7: Each column's two bits are cleared as that column is compared, so the next scan starts from empty records.
- R8: `chk_err` becomes 1 only on an edge where `sample` is high and either the error request or `other_err` is high. Such a sample consumes the error request unless a new mismatch arrives on the same edge.
- R9: `chk_err`, the error request, `fault_map` and the first-failure fields stay set until `clear` or reset. `clear` takes priority over `sample` and over a mismatch found on the same edge.
- R10: The first mismatch after a clear sets `err_col_vld` and latches its column on `err_col`. It also latches `err_kind`: bit 0 means commanded but not sensed, and bit 1 means sensed without a command. These values are held unchanged by later mismatches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fire_cmd_valid | input | 1 | A strike command is offered |
| fire_cmd_ready | output | 1 | Command can be taken (low during a walk) |
| fire_cmd_col | input | 8 | Column of the offered command |
| fire_sense_valid | input | 1 | A sensed strike pulse is offered |
| fire_sense_ready | output | 1 | Sensed pulse can be taken (low during a walk) |
| fire_sense_col | input | 8 | Column of the sensed pulse |
| scan_end | input | 1 | Scan boundary strobe, starts the comparison walk |
| sample | input | 1 | Sample strobe for the print-check latch |
| clear | input | 1 | Drops the latch, request, map and first-failure fields |
| other_err | input | 1 | Error request from other checkers, merged before the latch |
| busy | output | 1 | Comparison walk in progress |
| scan_done | output | 1 | One-cycle pulse after the last column is compared |
| chk_err | output | 1 | Sticky print-check error |
| err_col | output | 8 | First failing column since the last clear |
| err_col_vld | output | 1 | `err_col` and `err_kind` hold a failure |
| err_kind | output | 2 | Bit 0: missed strike; bit 1: unexpected strike |
| fault_map | output | 132 | Per-column record of mismatches since the last clear |

## Verification
A lost or stuck bit in either record shows up at the ports only at the next walk. It then appears as a `fault_map` bit and a first-failure column that are wrong within one clock of that column's slot. A walker that skips, repeats or overruns shows as `scan_done` arriving on the wrong cycle, or as ready staying low. A request that is not consumed, or not kept, shows on `chk_err` at the next sample strobe. The bench therefore compares every output with a behavioural model on every clock, so a divergence is reported in the cycle it first becomes visible.

// File: rtl/hf_pkg.sv
package hf_pkg;

  // Kind of the first recorded failure; bit 0 = missed, bit 1 = unexpected.
  typedef struct packed {
    logic unexpected;
    logic missed;
  } fail_kind_t;

endpackage

// File: rtl/hf_fire_record.sv
// One bit per column: set by an event, cleared when the walker visits it.
module hf_fire_record #(
  parameter int NUM_COLS = 132,
  parameter int COL_W    = $clog2(NUM_COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [COL_W-1:0] set_col,
  input  logic             rd_clr,
  input  logic [COL_W-1:0] rd_col,
  output logic             rd_bit
);

  logic [NUM_COLS-1:0] bits_q;
  logic [NUM_COLS-1:0] set_vec;
  logic [NUM_COLS-1:0] clr_vec;

  for (genvar g = 0; g < NUM_COLS; g++) begin : g_dec
    assign set_vec[g] = set_en && (set_col == COL_W'(g));
    assign clr_vec[g] = rd_clr && (rd_col == COL_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= (bits_q & ~clr_vec) | set_vec;
  end

  always_comb begin
    rd_bit = 1'b0;
    for (int i = 0; i < NUM_COLS; i++) begin
      if (rd_col == COL_W'(i)) rd_bit = bits_q[i];
    end
  end

endmodule

// File: rtl/hf_scan_walker.sv
// Steps a column index from 0 to NUM_COLS-1, one per clock, after a start strobe.
module hf_scan_walker #(
  parameter int NUM_COLS = 132,
  parameter int COL_W    = $clog2(NUM_COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [COL_W-1:0] col,
  output logic             done
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

  logic             busy_q;
  logic [COL_W-1:0] col_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      col_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= busy_q && (col_q == LAST_COL);
      if (busy_q) begin
        if (col_q == LAST_COL) busy_q <= 1'b0;
        else                   col_q  <= col_q + COL_W'(1);
      end else if (start) begin
        busy_q <= 1'b1;
        col_q  <= '0;
      end
    end
  end

  assign busy = busy_q;
  assign col  = col_q;
  assign done = done_q;

endmodule

// File: rtl/hf_fault_latch.sv
// Per-column fault map, error request, sampled sticky latch, first failure.
module hf_fault_latch
  import hf_pkg::*;
#(
  parameter int NUM_COLS = 132,
  parameter int COL_W    = $clog2(NUM_COLS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmp_en,
  input  logic [COL_W-1:0]    cmp_col,
  input  logic                cmd_bit,
  input  logic                hit_bit,
  input  logic                ext_err,
  input  logic                sample,
  input  logic                clear,
  output logic                chk_err,
  output logic [COL_W-1:0]    first_col,
  output logic                first_vld,
  output fail_kind_t          first_kind,
  output logic [NUM_COLS-1:0] fault_map
);

  logic                mismatch;
  logic [NUM_COLS-1:0] mis_vec;
  logic                req_q;
  logic                err_q;
  logic [COL_W-1:0]    col_q;
  logic                vld_q;
  fail_kind_t          kind_q;
  logic [NUM_COLS-1:0] map_q;

  assign mismatch = cmp_en && (cmd_bit != hit_bit);

  for (genvar g = 0; g < NUM_COLS; g++) begin : g_mis
    assign mis_vec[g] = mismatch && (cmp_col == COL_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      err_q  <= 1'b0;
      col_q  <= '0;
      vld_q  <= 1'b0;
      kind_q <= '0;
      map_q  <= '0;
    end else if (clear) begin
      req_q  <= 1'b0;
      err_q  <= 1'b0;
      col_q  <= '0;
      vld_q  <= 1'b0;
      kind_q <= '0;
      map_q  <= '0;
    end else begin
      if (sample && (req_q || ext_err)) err_q <= 1'b1;
      if (mismatch)    req_q <= 1'b1;
      else if (sample) req_q <= 1'b0;
      if (mismatch && !vld_q) begin
        vld_q             <= 1'b1;
        col_q             <= cmp_col;
        kind_q.unexpected <= hit_bit && !cmd_bit;
        kind_q.missed     <= cmd_bit && !hit_bit;
      end
      map_q <= map_q | mis_vec;
    end
  end

  assign chk_err    = err_q;
  assign first_col  = col_q;
  assign first_vld  = vld_q;
  assign first_kind = kind_q;
  assign fault_map  = map_q;

endmodule

// File: rtl/hammer_fire_checker.sv
module hammer_fire_checker
  import hf_pkg::*;
#(
  parameter int NUM_COLS = 132,
  parameter int COL_W    = $clog2(NUM_COLS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire_cmd_valid,
  output logic                fire_cmd_ready,
  input  logic [COL_W-1:0]    fire_cmd_col,
  input  logic                fire_sense_valid,
  output logic                fire_sense_ready,
  input  logic [COL_W-1:0]    fire_sense_col,
  input  logic                scan_end,
  input  logic                sample,
  input  logic                clear,
  input  logic                other_err,
  output logic                busy,
  output logic                scan_done,
  output logic                chk_err,
  output logic [COL_W-1:0]    err_col,
  output logic                err_col_vld,
  output logic [1:0]          err_kind,
  output logic [NUM_COLS-1:0] fault_map
);

  logic             walk_busy;
  logic [COL_W-1:0] walk_col;
  logic             cmd_take;
  logic             sense_take;
  logic             cmd_bit;
  logic             hit_bit;
  fail_kind_t       kind;

  assign fire_cmd_ready   = !walk_busy;
  assign fire_sense_ready = !walk_busy;
  assign cmd_take   = fire_cmd_valid && !walk_busy && (int'(fire_cmd_col) < NUM_COLS);
  assign sense_take = fire_sense_valid && !walk_busy && (int'(fire_sense_col) < NUM_COLS);

  hf_scan_walker #(.NUM_COLS(NUM_COLS), .COL_W(COL_W)) u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (scan_end),
    .busy  (walk_busy),
    .col   (walk_col),
    .done  (scan_done)
  );

  hf_fire_record #(.NUM_COLS(NUM_COLS), .COL_W(COL_W)) u_cmd_rec (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (cmd_take),
    .set_col (fire_cmd_col),
    .rd_clr  (walk_busy),
    .rd_col  (walk_col),
    .rd_bit  (cmd_bit)
  );

  hf_fire_record #(.NUM_COLS(NUM_COLS), .COL_W(COL_W)) u_hit_rec (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (sense_take),
    .set_col (fire_sense_col),
    .rd_clr  (walk_busy),
    .rd_col  (walk_col),
    .rd_bit  (hit_bit)
  );

  hf_fault_latch #(.NUM_COLS(NUM_COLS), .COL_W(COL_W)) u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_en     (walk_busy),
    .cmp_col    (walk_col),
    .cmd_bit    (cmd_bit),
    .hit_bit    (hit_bit),
    .ext_err    (other_err),
    .sample     (sample),
    .clear      (clear),
    .chk_err    (chk_err),
    .first_col  (err_col),
    .first_vld  (err_col_vld),
    .first_kind (kind),
    .fault_map  (fault_map)
  );

  assign busy     = walk_busy;
  assign err_kind = kind;

endmodule

// File: rtl/hammer_fire_checker_sva.sv
module hammer_fire_checker_sva #(
  parameter int NUM_COLS = 132,
  parameter int COL_W    = $clog2(NUM_COLS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sample,
  input logic                clear,
  input logic                busy,
  input logic                scan_done,
  input logic                chk_err,
  input logic [COL_W-1:0]    err_col,
  input logic                err_col_vld,
  input logic [1:0]          err_kind,
  input logic [NUM_COLS-1:0] fault_map
);

  AST_DONE_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> (!busy && $past(busy))); // R5

  AST_ERR_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chk_err) |-> $past(sample)); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_err && !clear) |=> chk_err); // R9

  AST_MAP_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((fault_map & $past(fault_map)) == $past(fault_map))); // R6

  AST_FIRST_COL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_col_vld && !clear) |=> ($stable(err_col) && $stable(err_kind))); // R10

  AST_KIND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_col_vld |-> ($countones(err_kind) == 1)); // R10

  AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    err_col_vld |-> (int'(err_col) < NUM_COLS)); // R10

endmodule

bind hammer_fire_checker hammer_fire_checker_sva #(.NUM_COLS(NUM_COLS), .COL_W(COL_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample      (sample),
  .clear       (clear),
  .busy        (busy),
  .scan_done   (scan_done),
  .chk_err     (chk_err),
  .err_col     (err_col),
  .err_col_vld (err_col_vld),
  .err_kind    (err_kind),
  .fault_map   (fault_map)
);

// File: tb/hammer_fire_checker_test.sv
`timescale 1ns/1ps
module hammer_fire_checker_test;

  localparam int NC = 132;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0, sense_valid = 1'b0;
  logic [7:0]    cmd_col = '0, sense_col = '0;
  logic          scan_end = 1'b0, sample = 1'b0, clear = 1'b0, other_err = 1'b0;
  logic          cmd_ready, sense_ready, busy, scan_done, chk_err, err_col_vld;
  logic [7:0]    err_col;
  logic [1:0]    err_kind;
  logic [NC-1:0] fault_map;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hammer_fire_checker uut (
    .clk(clk), .rst_n(rst_n),
    .fire_cmd_valid(cmd_valid), .fire_cmd_ready(cmd_ready), .fire_cmd_col(cmd_col),
    .fire_sense_valid(sense_valid), .fire_sense_ready(sense_ready), .fire_sense_col(sense_col),
    .scan_end(scan_end), .sample(sample), .clear(clear), .other_err(other_err),
    .busy(busy), .scan_done(scan_done), .chk_err(chk_err), .err_col(err_col),
    .err_col_vld(err_col_vld), .err_kind(err_kind), .fault_map(fault_map)
  );

  task automatic check(input string tag, input logic [NC-1:0] act, input logic [NC-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  bit [NC-1:0] m_cmd, m_hit, m_map;
  bit          m_walk, m_done, m_req, m_err, m_vld;
  int          m_idx, m_first;
  bit [1:0]    m_kind;
  bit          t_mis, t_c, t_h, t_rdy;
  int          t_i;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd = '0; m_hit = '0; m_map = '0; m_walk = 0; m_done = 0;
      m_req = 0; m_err = 0; m_vld = 0; m_idx = 0; m_first = 0; m_kind = 0;
    end else begin
      t_rdy = !m_walk; t_mis = 0; t_c = 0; t_h = 0; t_i = m_idx;
      if (m_walk) begin
        t_c = m_cmd[t_i]; t_h = m_hit[t_i]; t_mis = (t_c != t_h);
        m_cmd[t_i] = 0; m_hit[t_i] = 0;
      end
      if (cmd_valid && t_rdy && cmd_col < NC) m_cmd[cmd_col] = 1;
      if (sense_valid && t_rdy && sense_col < NC) m_hit[sense_col] = 1;
      m_done = m_walk && (m_idx == NC - 1);
      if (m_walk) begin
        if (m_idx == NC - 1) m_walk = 0; else m_idx++;
      end else if (scan_end) begin
        m_walk = 1; m_idx = 0;
      end
      if (clear) begin
        m_req = 0; m_err = 0; m_vld = 0; m_first = 0; m_kind = 0; m_map = '0;
      end else begin
        if (sample && (m_req || other_err)) m_err = 1;
        if (t_mis) m_req = 1; else if (sample) m_req = 0;
        if (t_mis) begin
          m_map[t_i] = 1;
          if (!m_vld) begin
            m_vld = 1; m_first = t_i; m_kind = {t_h & ~t_c, t_c & ~t_h};
          end
        end
      end
    end
  end

  // Every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R4 busy", busy, m_walk);
      check("R4 cmd ready", cmd_ready, !m_walk);
      check("R4 sense ready", sense_ready, !m_walk);
      check("R5 scan_done", scan_done, m_done);
      check("R8 chk_err", chk_err, m_err);
      check("R10 err_col_vld", err_col_vld, m_vld);
      check("R10 err_col", err_col, m_first);
      check("R10 err_kind", err_kind, m_kind);
      check("R6 fault_map", fault_map, m_map);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic run_scan();
    scan_end = 1; tick(); scan_end = 0;
    while (!scan_done) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 ready", {cmd_ready, sense_ready}, 2'b11);
    check("R1 chk_err", chk_err, 0);
    check("R1 fault_map", fault_map, '0);
    check("R1 err_col_vld", err_col_vld, 0);
    rst_n = 1; tick();

    // Scan A: matches at 0 and 131, missed at 5, unexpected at 7, out-of-range 140
    cmd_valid = 1; cmd_col = 0; sense_valid = 1; sense_col = 0; tick();
    cmd_col = 5; sense_col = 7; tick();
    cmd_col = 131; sense_col = 131; tick();
    cmd_col = 140; sense_valid = 0; tick();
    cmd_valid = 0;
    run_scan();
    check("R6 map after scan A", fault_map, (NC'(1) << 5) | (NC'(1) << 7));
    check("R2 out-of-range ignored", fault_map[NC-1:8], '0);
    check("R10 first col", err_col, 5);
    check("R10 first kind missed", err_kind, 2'b01);
    check("R8 no latch without sample", chk_err, 0);
    sample = 1; tick(); sample = 0;
    check("R8 latch on sample", chk_err, 1);
    sample = 1; tick(); sample = 0;
    check("R9 sticky", chk_err, 1);
    clear = 1; tick(); clear = 0;
    check("R9 clear latch", chk_err, 0);
    check("R9 clear map", fault_map, '0);
    check("R9 clear first", err_col_vld, 0);

    // Scan B: nothing offered, records must be empty
    run_scan();
    check("R7 clean records", fault_map, '0);
    sample = 1; tick(); sample = 0;
    check("R7 no request after clean scan", chk_err, 0);

    // Other error source merged
    other_err = 1; tick();
    check("R8 other_err without sample", chk_err, 0);
    sample = 1; tick(); sample = 0; other_err = 0;
    check("R8 other_err sampled", chk_err, 1);
    clear = 1; tick(); clear = 0;

    // Events and scan_end while walking are held off
    scan_end = 1; tick(); scan_end = 0;
    cmd_valid = 1; cmd_col = 3; sense_valid = 1; sense_col = 9; scan_end = 1;
    repeat (5) tick();
    check("R4 ready low in walk", {cmd_ready, sense_ready}, 2'b00);
    cmd_valid = 0; sense_valid = 0; scan_end = 0;
    while (!scan_done) tick();
    check("R2 held-off command not taken", fault_map, '0);
    tick();
    check("R4 idle after walk", busy, 0);

    // Sensed without command
    sense_valid = 1; sense_col = 20; tick(); sense_valid = 0;
    run_scan();
    check("R3 unexpected col", err_col, 20);
    check("R3 kind unexpected", err_kind, 2'b10);
    cmd_valid = 1; cmd_col = 30; tick(); cmd_valid = 0;
    run_scan();
    check("R10 first col held", err_col, 20);
    check("R6 map accumulates", fault_map, (NC'(1) << 20) | (NC'(1) << 30));

    // Clear beats sample
    sample = 1; clear = 1; tick(); sample = 0; clear = 0;
    check("R9 clear over sample", chk_err, 0);
    sample = 1; tick(); sample = 0;
    check("R9 request dropped by clear", chk_err, 0);

    repeat (2) tick();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule